// File: doc/BRIEF.md
# Triggered Acquisition Capture Channel

The block records one 8-bit sample stream for test acquisition. Each clock cycle a new sample enters a delay line whose tap can be set up to 256 words back. This tap stands in for the latency before the trigger decision arrives. The trigger input has its own programmable delay line. When the delayed trigger is accepted, samples from the selected tap are written into a 1024-word dual-port memory. A host reads that memory through a registered address/data port, and it can do so while capture is still running.

In single mode each accepted trigger stores one word. In burst mode each accepted trigger stores a run of 1 to 32 consecutive samples. A pre-trigger count sets how many of those samples come before the triggering sample. The sample tap is moved back by that count, so the earlier samples are already in the delay line. A run ends in one of two ways: the event count reaches a programmable maximum, or the memory fills. Triggers that arrive while a burst is still being written are dropped, and each one adds to a saturating overlap counter. A run-start pulse clears the write pointer, the event count and the overlap count.

Top module: `acq_capture`

## Requirements
- R1: Two cycles after reset is released, `wr_ptr`, `event_count` and `overlap_count` read 0, `rd_data` reads 0, and `done` reads 0 whenever `cfg_max_events` is non-zero.
- R2: Sample and trigger edges are numbered in order. In single mode (`cfg_burst_mode`=0), a trigger seen at edge t that is accepted stores exactly one word. The word is the `din` value from edge t+D-L, where D is `cfg_trig_delay` and L is `cfg_latency`. It is written at address `wr_ptr`, and `wr_ptr` then increases by one.
- R3: In burst mode, an accepted trigger seen at edge t stores N words at consecutive addresses. Word j is the `din` value from edge t+D-L-P+j, where P is `cfg_pre_trig` (meant to be below N). It ignores `cfg_pre_trig` in single mode. The first word is written at the edge when the delayed trigger fires, and one more word is written on each following edge.
- R4: The burst length N equals `cfg_burst_len`, with two exceptions. A value of 0 gives N=1, and any value above 32 gives N=32.
- R5: A trigger that fires while a burst is being written is ignored and stores nothing. `overlap_count` rises by one for each such trigger and stays at 255 once it gets there.
- R6: `event_count` rises by one for each accepted trigger. A trigger is accepted only when no burst is in progress and `event_count` is below `cfg_max_events`. `done` is 1 when the count has reached the maximum and no burst is active.
- R7: Writes stop at 1024 stored words, even in the middle of a burst. After that, `wr_ptr` stays at 1024 and `done` is 1.
- R8: A `run_start` pulse clears `wr_ptr`, `event_count` and `overlap_count`, and it ends any active burst. No word is written in that cycle and no trigger is accepted.
- R9: `rd_data` shows the memory word at `rd_addr` one clock after the address is presented. This holds while capture is running.
- R10: Triggers that fire while `done` is 1 are not stored and do not change `overlap_count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Sample stream, one sample per cycle |
| trig | input | 1 | Trigger request |
| run_start | input | 1 | Pulse that clears the pointer and counters |
| cfg_burst_mode | input | 1 | 0 = single word per trigger, 1 = burst |
| cfg_latency | input | 8 | Delay-line tap L |
| cfg_trig_delay | input | 6 | Extra trigger delay D |
| cfg_burst_len | input | 6 | Burst length N (clamped to 1..32) |
| cfg_pre_trig | input | 5 | Pre-trigger samples P in burst mode |
| cfg_max_events | input | 11 | Maximum accepted triggers per run |
| rd_addr | input | 10 | Host read address |
| rd_data | output | 8 | Host read data, one cycle after address |
| wr_ptr | output | 11 | Next write address / words stored |
| event_count | output | 11 | Accepted triggers this run |
| overlap_count | output | 8 | Saturating count of dropped triggers |
| done | output | 1 | Event limit reached or memory full |

## Verification
The bench builds the block with its default parameters: a 256-deep latency line, a 64-deep trigger delay, bursts of up to 32 words and a 1024-word memory. With these values the bench can reach the deepest sample tap (latency 255 plus pre-trigger 31), which tests that the delay line is long enough for the pre-trigger shift. A 30-word burst length fills the memory in the middle of a burst, and continuous triggering with 32-word bursts drives the overlap counter to its saturation value in a few hundred cycles.

// File: rtl/acq_capture_pkg.sv
package acq_capture_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_BURST  = 1'b1
  } cap_mode_e;

endpackage

// File: rtl/acq_delay_line.sv
module acq_delay_line #(
  parameter int W     = 8,
  parameter int LEN   = 288,
  parameter int SEL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     d_in,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     tap
);

  logic [W-1:0] stg_q [LEN];
  logic [W-1:0] stg_d [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stg_d[i] = d_in;
    end else begin : g_body
      assign stg_d[i] = stg_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d[i];
    end
  end

  // Tap k holds the value accepted k+1 edges earlier.
  assign tap = (int'(sel) < LEN) ? stg_q[sel] : '0;

endmodule

// File: rtl/acq_dpram.sv
module acq_dpram #(
  parameter int W     = 8,
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem_q[raddr];
  end

endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_capture_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  parameter int MAX_BURST = 32,
  parameter int PTR_W     = $clog2(MEM_DEPTH) + 1,
  parameter int LEN_W     = $clog2(MAX_BURST) + 1,
  parameter int OVL_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             run_start,
  input  logic             burst_mode,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [PTR_W-1:0] max_events,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] event_count,
  output logic [OVL_W-1:0] overlap_count,
  output logic             done
);

  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(MAX_BURST);
  localparam logic [PTR_W-1:0] PTR_FULL  = PTR_W'(MEM_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(MEM_DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d, evt_q, evt_d;
  logic [OVL_W-1:0] ovl_q, ovl_d;
  logic [LEN_W-1:0] rem_q, rem_d, len_eff;
  logic             busy_q, busy_d;
  logic             full, last_slot, at_limit, start;
  logic             ptr_en, evt_en, ovl_en, burst_en;

  // Effective burst length: single mode or zero gives 1, clamp to maximum.
  always_comb begin
    len_eff = LEN_W'(1);
    if (cap_mode_e'(burst_mode) == MODE_BURST) begin
      if (burst_len == '0)         len_eff = LEN_W'(1);
      else if (burst_len > LEN_MAX) len_eff = LEN_MAX;
      else                          len_eff = burst_len;
    end
  end

  assign full      = (ptr_q == PTR_FULL);
  assign last_slot = (ptr_q == PTR_LAST);
  assign at_limit  = (evt_q >= max_events);
  assign start     = fire & ~busy_q & ~at_limit & ~full & ~run_start;
  assign wr_en     = (start | busy_q) & ~full & ~run_start;

  always_comb begin
    ptr_d  = ptr_q;
    evt_d  = evt_q;
    ovl_d  = ovl_q;
    rem_d  = rem_q;
    busy_d = busy_q;
    if (run_start) begin
      ptr_d  = '0;
      evt_d  = '0;
      ovl_d  = '0;
      rem_d  = '0;
      busy_d = 1'b0;
    end else begin
      if (wr_en) ptr_d = ptr_q + PTR_W'(1);
      if (start) begin
        evt_d  = evt_q + PTR_W'(1);
        rem_d  = len_eff - LEN_W'(1);
        busy_d = (len_eff > LEN_W'(1)) && !last_slot;
      end else if (busy_q) begin
        rem_d  = rem_q - LEN_W'(1);
        busy_d = (rem_q > LEN_W'(1)) && !last_slot && !full;
      end
      if (busy_q && fire && (ovl_q != '1)) ovl_d = ovl_q + OVL_W'(1);
    end
  end

  assign ptr_en   = wr_en | run_start;
  assign evt_en   = start | run_start;
  assign ovl_en   = run_start | (busy_q & fire);
  assign burst_en = start | busy_q | run_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      evt_q  <= '0;
      ovl_q  <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (ptr_en)   ptr_q  <= ptr_d;
      if (evt_en)   evt_q  <= evt_d;
      if (ovl_en)   ovl_q  <= ovl_d;
      if (burst_en) begin
        rem_q  <= rem_d;
        busy_q <= busy_d;
      end
    end
  end

  assign wr_ptr        = ptr_q;
  assign event_count   = evt_q;
  assign overlap_count = ovl_q;
  assign done          = full | (at_limit & ~busy_q);

  // R7: once the memory is full the pointer does not move
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !run_start) |=> $stable(ptr_q));

  // R5: overlap counter stays saturated
  a_r5_ovl_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovl_q == '1) && !run_start) |=> (ovl_q == '1));

  // R5: no trigger is accepted while a burst is being written
  a_r5_busy_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !run_start) |=> $stable(evt_q));

  // R6: no trigger is accepted once done
  a_r6_done_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !run_start) |=> $stable(evt_q));

  // R8: run start clears pointer, count, overlap and burst
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (ptr_q == '0 && evt_q == '0 && ovl_q == '0 && !busy_q));

  // R2: single mode never leaves a burst pending
  a_r2_single_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_mode && !busy_q) |=> !busy_q);

endmodule

// File: rtl/acq_capture.sv
module acq_capture
  import acq_capture_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LAT_DEPTH = 256,
  parameter int TDLY_DEPTH = 64,
  parameter int MAX_BURST = 32,
  parameter int MEM_DEPTH = 1024,
  parameter int LAT_W     = $clog2(LAT_DEPTH),
  parameter int TDLY_W    = $clog2(TDLY_DEPTH),
  parameter int LEN_W     = $clog2(MAX_BURST) + 1,
  parameter int PRE_W     = $clog2(MAX_BURST),
  parameter int AW        = $clog2(MEM_DEPTH),
  parameter int PTR_W     = $clog2(MEM_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              trig,
  input  logic              run_start,
  input  logic              cfg_burst_mode,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic [TDLY_W-1:0] cfg_trig_delay,
  input  logic [LEN_W-1:0]  cfg_burst_len,
  input  logic [PRE_W-1:0]  cfg_pre_trig,
  input  logic [PTR_W-1:0]  cfg_max_events,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  event_count,
  output logic [7:0]        overlap_count,
  output logic              done
);

  localparam int LINE_LEN = LAT_DEPTH + MAX_BURST;
  localparam int SEL_W    = $clog2(LINE_LEN);

  logic              rst_meta_q, rst_sync_n;
  logic              fire, wr_en;
  logic [PRE_W-1:0]  pre_eff;
  logic [SEL_W-1:0]  tap_sel;
  logic [DATA_W-1:0] tap_data;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  assign pre_eff = (cap_mode_e'(cfg_burst_mode) == MODE_BURST) ? cfg_pre_trig : '0;
  assign tap_sel = SEL_W'(cfg_latency) + SEL_W'(pre_eff);

  acq_delay_line #(.W(DATA_W), .LEN(LINE_LEN), .SEL_W(SEL_W)) u_sample_line (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (din),
    .sel   (tap_sel),
    .tap   (tap_data)
  );

  acq_delay_line #(.W(1), .LEN(TDLY_DEPTH), .SEL_W(TDLY_W)) u_trig_line (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (trig),
    .sel   (cfg_trig_delay),
    .tap   (fire)
  );

  acq_seq #(.MEM_DEPTH(MEM_DEPTH), .MAX_BURST(MAX_BURST),
            .PTR_W(PTR_W), .LEN_W(LEN_W), .OVL_W(8)) u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .fire          (fire),
    .run_start     (run_start),
    .burst_mode    (cfg_burst_mode),
    .burst_len     (cfg_burst_len),
    .max_events    (cfg_max_events),
    .wr_en         (wr_en),
    .wr_ptr        (wr_ptr),
    .event_count   (event_count),
    .overlap_count (overlap_count),
    .done          (done)
  );

  acq_dpram #(.W(DATA_W), .DEPTH(MEM_DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (wr_en),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (tap_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R7: pointer never passes the memory size
  a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ptr <= PTR_W'(MEM_DEPTH));

  // R10: a done run does not count overlaps
  a_r10_done_no_overlap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !run_start) |=> $stable(overlap_count));

endmodule

// File: tb/acq_capture_tb_top.sv
`timescale 1ns/1ps
module acq_capture_tb_top;

  localparam int HLEN = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  din = '0;
  logic        trig = 1'b0;
  logic        run_start = 1'b0;
  logic        mode = 1'b0;
  logic [7:0]  lat = '0;
  logic [5:0]  tdly = '0;
  logic [5:0]  blen = 6'd1;
  logic [4:0]  pre = '0;
  logic [10:0] maxev = 11'd1024;
  logic [9:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [10:0] wr_ptr, event_count;
  logic [7:0]  overlap_count;
  logic        done;

  always #2.5 clk = ~clk;

  acq_capture dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .trig(trig), .run_start(run_start),
    .cfg_burst_mode(mode), .cfg_latency(lat), .cfg_trig_delay(tdly),
    .cfg_burst_len(blen), .cfg_pre_trig(pre), .cfg_max_events(maxev),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr),
    .event_count(event_count), .overlap_count(overlap_count), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit        mdl_on = 1'b0;
  int        cyc = 0;
  logic [7:0] h [HLEN];
  bit        tr [HLEN];
  logic [7:0] exp_mem [1024];
  int m_wptr = 0, m_evt = 0, m_ovl = 0, m_rem = 0, m_base = 0, m_j = 0;
  bit m_busy = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int n_eff();
    if (!mode) return 1;
    if (blen == 0) return 1;
    if (blen > 32) return 32;
    return int'(blen);
  endfunction

  function automatic int m_done();
    return ((m_wptr == 1024) || (m_evt >= int'(maxev) && !m_busy)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (mdl_on && cyc < HLEN) begin
      int  fi;
      bit  fire, start;
      h[cyc]  = din;
      tr[cyc] = trig;
      fi   = cyc - 1 - int'(tdly);
      fire = (fi >= 0) ? tr[fi] : 1'b0;
      if (run_start) begin
        m_wptr = 0; m_evt = 0; m_ovl = 0; m_busy = 1'b0; m_rem = 0;
      end else begin
        if (m_busy && fire && m_ovl < 255) m_ovl++;
        start = fire && !m_busy && (m_evt < int'(maxev)) && (m_wptr < 1024);
        if (start) begin
          m_evt++;
          m_base = cyc - 1 - int'(lat) - (mode ? int'(pre) : 0);
          m_j = 0;
          m_rem = n_eff();
          m_busy = 1'b1;
        end
        if (m_busy && m_wptr < 1024) begin
          int idx;
          idx = m_base + m_j;
          exp_mem[m_wptr] = (idx >= 0) ? h[idx] : 8'd0;
          m_wptr++; m_j++; m_rem--;
          if (m_rem == 0 || m_wptr == 1024) m_busy = 1'b0;
        end else begin
          m_busy = 1'b0;
        end
      end
      cyc++;
    end
  end

  // per-cycle comparison of status outputs against the model
  always @(negedge clk) begin
    if (mdl_on && !finished) begin
      chk({cur_req, " wr_ptr"}, int'(wr_ptr), m_wptr);
      chk({cur_req, " event_count"}, int'(event_count), m_evt);
      chk({cur_req, " overlap_count"}, int'(overlap_count), m_ovl);
      chk({cur_req, " done"}, int'(done), m_done());
    end
  end

  task automatic run_cycles(input int n, input int pct, input bit do_reads);
    bit pend = 1'b0;
    int pexp = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pend) chk("R9 read during capture", int'(rd_data), pexp);
      din  = 8'($urandom);
      trig = (($urandom % 100) < pct);
      pend = 1'b0;
      if (do_reads && m_wptr > 0) begin
        rd_addr = 10'($urandom % m_wptr);
        pexp = int'(exp_mem[rd_addr]);
        pend = 1'b1;
      end
    end
    @(negedge clk);
    if (pend) chk("R9 read during capture", int'(rd_data), pexp);
    trig = 1'b0;
  endtask

  task automatic readback(input string req);
    int n;
    n = m_wptr;
    for (int a = 0; a < n; a++) begin
      @(negedge clk);
      rd_addr = 10'(a);
      @(negedge clk);
      chk(req, int'(rd_data), int'(exp_mem[a]));
    end
  endtask

  task automatic restart();
    @(negedge clk);
    trig = 1'b0;
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
  endtask

  task automatic one_trig();
    @(negedge clk);
    din = 8'($urandom);
    trig = 1'b1;
    @(negedge clk);
    din = 8'($urandom);
    trig = 1'b0;
  endtask

  initial begin
    int ov;
    void'($urandom(32'd715));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mdl_on = 1'b1;
    @(negedge clk);
    chk("R1 wr_ptr", int'(wr_ptr), 0);
    chk("R1 event_count", int'(event_count), 0);
    chk("R1 overlap_count", int'(overlap_count), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // single mode, moderate latency and delay
    cur_req = "R2"; mode = 1'b0; lat = 8'd5; tdly = 6'd3;
    run_cycles(400, 8, 1'b1);
    run_cycles(80, 0, 1'b0);
    readback("R2 single-mode word");

    // latency corners
    restart(); cur_req = "R2"; lat = 8'd0; tdly = 6'd0;
    run_cycles(20, 0, 1'b0);
    one_trig(); run_cycles(10, 0, 1'b0);
    lat = 8'd255; tdly = 6'd63;
    run_cycles(300, 0, 1'b0);
    one_trig(); run_cycles(100, 0, 1'b0);
    readback("R2 latency corner word");

    // burst mode with pre-trigger and overlap
    restart(); cur_req = "R3"; mode = 1'b1; blen = 6'd8; pre = 5'd3;
    lat = 8'd17; tdly = 6'd9;
    run_cycles(600, 10, 1'b1);
    run_cycles(100, 0, 1'b0);
    readback("R3 burst word");
    chk("R5 overlaps seen", (overlap_count > 0) ? 1 : 0, 1);

    // deepest tap: latency 255 plus pre 31
    restart(); cur_req = "R3"; blen = 6'd32; pre = 5'd31; lat = 8'd255; tdly = 6'd0;
    run_cycles(320, 0, 1'b0);
    one_trig(); run_cycles(60, 0, 1'b0);
    readback("R3 deepest tap word");

    // length clamps
    restart(); cur_req = "R4"; pre = 5'd0; lat = 8'd2; blen = 6'd0;
    one_trig(); run_cycles(10, 0, 1'b0);
    chk("R4 zero length stores one", int'(wr_ptr), 1);
    blen = 6'd40;
    one_trig(); run_cycles(50, 0, 1'b0);
    chk("R4 long length clamped", int'(wr_ptr), 33);
    readback("R4 clamp word");

    // event limit and done behaviour
    restart(); cur_req = "R6"; blen = 6'd4; pre = 5'd1; maxev = 11'd3;
    run_cycles(200, 20, 1'b0);
    chk("R6 event limit", int'(event_count), 3);
    chk("R6 done", int'(done), 1);
    ov = int'(overlap_count);
    cur_req = "R10";
    run_cycles(100, 50, 1'b0);
    chk("R10 overlap unchanged when done", int'(overlap_count), ov);
    chk("R10 nothing stored when done", int'(wr_ptr), 12);
    readback("R6 limited run word");

    // fill memory mid-burst
    restart(); cur_req = "R7"; maxev = 11'd1024; blen = 6'd30; pre = 5'd5; lat = 8'd20;
    for (int k = 0; k < 40 && m_wptr < 1024; k++) run_cycles(50, 6, 1'b0);
    while (m_wptr < 1024 && cyc < HLEN - 4000) run_cycles(40, 20, 1'b0);
    run_cycles(40, 20, 1'b0);
    chk("R7 pointer stops at 1024", int'(wr_ptr), 1024);
    chk("R7 done when full", int'(done), 1);
    readback("R7 full memory word");

    // overlap saturation
    restart(); cur_req = "R5"; blen = 6'd32; pre = 5'd0; lat = 8'd1;
    run_cycles(320, 100, 1'b0);
    run_cycles(40, 0, 1'b0);
    chk("R5 overlap saturates", int'(overlap_count), 255);

    // run start clears everything
    cur_req = "R8";
    restart();
    @(negedge clk);
    chk("R8 wr_ptr cleared", int'(wr_ptr), 0);
    chk("R8 event_count cleared", int'(event_count), 0);
    chk("R8 overlap cleared", int'(overlap_count), 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule